// File: doc/BRIEF.md
# Transmit Frame Pad and FCS Appender

This stage sits in a byte-wide transmit path. It takes outgoing Ethernet frames that run from the destination address to the last payload byte and carry no check sequence. Frames arrive on a valid/ready stream with start and end markers. The stage can extend short frames with zero bytes to the minimum body length. It can also compute the Ethernet CRC-32 over the body and append it as a four-byte frame check sequence. Body bytes pass straight through with no added latency. The pad and check-sequence beats are generated locally, and the input stream is held off while they are sent.

Two mode bits come from a small register write port. The pad word enables padding, and the CRC word enables check-sequence insertion. Padding without CRC insertion is not a legal setting: the block raises an error output and does not pad in that state. A frame uses the modes that are in force when its first byte is accepted. A change that arrives in the middle of a frame applies from the next frame onward.

Top module: `tx_pad_fcs`

## Requirements
- R1: After reset, the pad word reads 0x1, the CRC word reads 0x3, `cfg_err` is 0 and `m_valid` is 0.
- R2: The pad word (`cfg_sel`=0) holds the pad enable in bit 0. Its bits 31..1 read as 0 whatever is written to them.
- R3: The CRC word (`cfg_sel`=1) holds the CRC enable in bit 1. Its bit 0 always reads 1, and bits 31..2 read as 0 whatever is written to them.
- R4: `cfg_err` is 1 exactly while the pad enable is 1 and the CRC enable is 0.
- R5: Body bytes appear on the output unchanged and in order. `m_sof` marks the first output byte of each frame.
- R6: With padding and CRC both enabled, a body shorter than 60 bytes is followed by zero bytes until the body totals 60 bytes.
- R7: A body of 60 bytes or more is never padded.
- R8: With CRC enabled, four check-sequence bytes follow the body, including any pad bytes. The value is the CRC-32 with reflected polynomial 0xEDB88320, preset all ones and final inversion, sent least significant byte first. `m_eof` is set on the fourth of these bytes. For the body "123456789" the bytes are 26 39 F4 CB.
- R9: With CRC disabled, no bytes are appended, and `m_eof` is set on the last body byte.
- R10: With the pad enable at 1 and the CRC enable at 0, frames are not padded.
- R11: A frame uses the mode bits that are in force when its first byte is accepted. Writes made during the frame apply from the next frame onward.
- R12: While `m_ready` is low, no output byte is lost or duplicated. During pad and check-sequence beats, `m_valid` and `m_data` hold steady.
- R13: While pad or check-sequence beats are being sent, `s_ready` is 0 and `m_sof` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Word select: 0 pad word, 1 CRC word |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected word |
| cfg_err | output | 1 | Padding enabled while CRC insertion is disabled |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted when high with s_valid |
| s_data | input | 8 | Input byte |
| s_sof | input | 1 | First byte of a frame |
| s_eof | input | 1 | Last body byte of a frame |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream can take a byte |
| m_data | output | 8 | Output byte |
| m_sof | output | 1 | First output byte of a frame |
| m_eof | output | 1 | Last output byte of a frame |

## Verification
The bench builds the block with a minimum body of 60 bytes and 32-bit control words, the values a real 64-byte minimum frame needs. At these values, bodies of 1, 59, 60 and 61 bytes sit on both sides of the pad threshold, and the saturating length counter is exercised by a 100-byte body. The 32-bit word width makes writes of all ones meaningful for checking that reserved bits read as zero. Random downstream stalls fall on body, pad and check-sequence beats alike.

// File: rtl/tx_pad_fcs_pkg.sv
package tx_pad_fcs_pkg;

    localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;
    localparam logic [31:0] CRC_PRESET = 32'hFFFFFFFF;
    localparam int          FCS_BYTES  = 4;

    typedef enum logic [1:0] {
        ST_BODY = 2'd0,
        ST_PAD  = 2'd1,
        ST_FCS  = 2'd2
    } seq_state_e;

    // effective per-frame mode: pad already gated by crc enable
    typedef struct packed {
        logic pad;
        logic fcs;
    } tx_mode_t;

    // one byte of reflected CRC-32, LSB of the byte first
    function automatic logic [31:0] crc32_next(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'h0, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/tx_ctl_regs.sv
module tx_ctl_regs
    import tx_pad_fcs_pkg::*;
#(
    parameter int CFG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             sel,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output tx_mode_t         live_mode,
    output logic             err
);

    logic pad_en_q;
    logic crc_en_q;
    logic unused_wbits;

    assign unused_wbits = ^wdata[CFG_W-1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            pad_en_q <= 1'b1;
            crc_en_q <= 1'b1;
        end else if (we) begin
            if (sel) crc_en_q <= wdata[1];
            else     pad_en_q <= wdata[0];
        end
    end

    always_comb begin
        rdata = '0;
        if (sel) begin
            rdata[1] = crc_en_q;
            rdata[0] = 1'b1;
        end else begin
            rdata[0] = pad_en_q;
        end
    end

    assign live_mode.pad = pad_en_q & crc_en_q;
    assign live_mode.fcs = crc_en_q;
    assign err           = pad_en_q & ~crc_en_q;

endmodule

// File: rtl/tx_crc32_acc.sv
module tx_crc32_acc
    import tx_pad_fcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    input  logic        init,
    input  logic [7:0]  din,
    output logic [31:0] crc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc <= CRC_PRESET;
        end else if (step) begin
            crc <= crc32_next(init ? CRC_PRESET : crc, din);
        end
    end

endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
    import tx_pad_fcs_pkg::*;
#(
    parameter int MIN_BODY = 60
) (
    input  logic        clk,
    input  logic        rst,
    input  tx_mode_t    live_mode,
    input  logic        s_valid,
    input  logic [7:0]  s_data,
    input  logic        s_sof,
    input  logic        s_eof,
    output logic        s_ready,
    input  logic        m_ready,
    output logic        m_valid,
    output logic [7:0]  m_data,
    output logic        m_sof,
    output logic        m_eof,
    input  logic [31:0] crc_i,
    output logic        crc_step,
    output logic        crc_init,
    output logic [7:0]  crc_din,
    output seq_state_e  state_o
);

    localparam int CNT_W = $clog2(MIN_BODY + 1);
    localparam int IDX_W = $clog2(FCS_BYTES);
    localparam logic [CNT_W-1:0] CNT_MIN  = CNT_W'(MIN_BODY);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FCS_BYTES - 1);

    seq_state_e       state_q;
    tx_mode_t         mode_q;
    tx_mode_t         eff;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] body_cnt;
    logic [IDX_W-1:0] idx_q;
    logic [31:0]      fcs_word;
    logic             need_pad;

    assign cnt_inc  = (cnt_q == CNT_MIN) ? cnt_q : cnt_q + 1'b1;
    assign body_cnt = s_sof ? CNT_W'(1) : cnt_inc;
    assign eff      = s_sof ? live_mode : mode_q;
    assign need_pad = eff.pad && (body_cnt < CNT_MIN);
    assign fcs_word = ~crc_i;
    assign state_o  = state_q;

    always_comb begin
        m_valid  = 1'b0;
        s_ready  = 1'b0;
        m_data   = 8'h00;
        m_sof    = 1'b0;
        m_eof    = 1'b0;
        crc_step = 1'b0;
        crc_init = 1'b0;
        crc_din  = 8'h00;
        case (state_q)
            ST_BODY: begin
                m_valid  = s_valid;
                s_ready  = m_ready;
                m_data   = s_data;
                m_sof    = s_sof;
                m_eof    = s_eof && !need_pad && !eff.fcs;
                crc_step = s_valid && m_ready;
                crc_init = s_sof;
                crc_din  = s_data;
            end
            ST_PAD: begin
                m_valid  = 1'b1;
                crc_step = m_ready;
            end
            ST_FCS: begin
                m_valid = 1'b1;
                m_data  = fcs_word[{idx_q, 3'b000} +: 8];
                m_eof   = (idx_q == IDX_LAST);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BODY;
            mode_q  <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            case (state_q)
                ST_BODY: begin
                    if (s_valid && m_ready) begin
                        cnt_q <= body_cnt;
                        if (s_sof) mode_q <= live_mode;
                        if (s_eof) begin
                            if (need_pad) begin
                                state_q <= ST_PAD;
                            end else if (eff.fcs) begin
                                state_q <= ST_FCS;
                                idx_q   <= '0;
                            end
                        end
                    end
                end
                ST_PAD: begin
                    if (m_ready) begin
                        cnt_q <= cnt_inc;
                        if (cnt_inc == CNT_MIN) begin
                            state_q <= ST_FCS;
                            idx_q   <= '0;
                        end
                    end
                end
                ST_FCS: begin
                    if (m_ready) begin
                        if (idx_q == IDX_LAST) state_q <= ST_BODY;
                        else                   idx_q   <= idx_q + 1'b1;
                    end
                end
                default: state_q <= ST_BODY;
            endcase
        end
    end

endmodule

// File: rtl/tx_pad_fcs.sv
module tx_pad_fcs
    import tx_pad_fcs_pkg::*;
#(
    parameter int MIN_BODY = 60,
    parameter int CFG_W    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             cfg_err,
    input  logic             s_valid,
    output logic             s_ready,
    input  logic [7:0]       s_data,
    input  logic             s_sof,
    input  logic             s_eof,
    output logic             m_valid,
    input  logic             m_ready,
    output logic [7:0]       m_data,
    output logic             m_sof,
    output logic             m_eof
);

    tx_mode_t    live_mode;
    seq_state_e  seq_state;
    logic [31:0] crc_val;
    logic        crc_step;
    logic        crc_init;
    logic [7:0]  crc_din;

    tx_ctl_regs #(.CFG_W(CFG_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .sel       (cfg_sel),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .live_mode (live_mode),
        .err       (cfg_err)
    );

    tx_crc32_acc u_crc (
        .clk  (clk),
        .rst  (rst),
        .step (crc_step),
        .init (crc_init),
        .din  (crc_din),
        .crc  (crc_val)
    );

    tx_frame_seq #(.MIN_BODY(MIN_BODY)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .live_mode (live_mode),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .s_sof     (s_sof),
        .s_eof     (s_eof),
        .s_ready   (s_ready),
        .m_ready   (m_ready),
        .m_valid   (m_valid),
        .m_data    (m_data),
        .m_sof     (m_sof),
        .m_eof     (m_eof),
        .crc_i     (crc_val),
        .crc_step  (crc_step),
        .crc_init  (crc_init),
        .crc_din   (crc_din),
        .state_o   (seq_state)
    );

endmodule

// File: rtl/tx_pad_fcs_chk.sv
module tx_pad_fcs_chk
    import tx_pad_fcs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       s_valid,
    input logic       s_ready,
    input logic       s_sof,
    input logic       s_eof,
    input logic       m_valid,
    input logic       m_ready,
    input logic [7:0] m_data,
    input logic       m_sof,
    input logic       m_eof,
    input logic       cfg_err,
    input seq_state_e st
);

    logic [2:0] fcs_seen;
    logic       ext;

    assign ext = (st != ST_BODY);

    always_ff @(posedge clk) begin
        if (rst) fcs_seen <= '0;
        else if (m_valid && m_ready && st == ST_FCS) fcs_seen <= m_eof ? 3'd0 : fcs_seen + 3'd1;
    end

    assert_fcs_four_R8: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_ready && m_eof && st == ST_FCS) |-> (fcs_seen == 3'd3));

    assert_ext_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (ext && m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_eof)));

    assert_no_take_R13: assert property (@(posedge clk) disable iff (rst)
        ext |-> !s_ready);

    assert_ext_no_sof_R13: assert property (@(posedge clk) disable iff (rst)
        (ext && m_valid) |-> !m_sof);

    assert_pad_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PAD) |-> (m_valid && m_data == 8'h00));

    assert_err_no_pad_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_err && s_valid && s_ready && s_sof && s_eof) |=> (st != ST_PAD));

endmodule

bind tx_pad_fcs tx_pad_fcs_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_sof   (s_sof),
    .s_eof   (s_eof),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_data  (m_data),
    .m_sof   (m_sof),
    .m_eof   (m_eof),
    .cfg_err (cfg_err),
    .st      (seq_state)
);

// File: tb/tx_pad_fcs_test.sv
module tx_pad_fcs_test;

    localparam int MIN_BODY = 60;
    localparam int CFG_W    = 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic             cfg_sel = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic [CFG_W-1:0] cfg_rdata;
    logic             cfg_err;
    logic             s_valid = 1'b0;
    logic             s_ready;
    logic [7:0]       s_data = 8'h00;
    logic             s_sof = 1'b0;
    logic             s_eof = 1'b0;
    logic             m_valid;
    logic             m_ready = 1'b1;
    logic [7:0]       m_data;
    logic             m_sof;
    logic             m_eof;

    tx_pad_fcs #(.MIN_BODY(MIN_BODY), .CFG_W(CFG_W)) uut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .s_sof(s_sof), .s_eof(s_eof),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
        .m_sof(m_sof), .m_eof(m_eof)
    );

    always #10 clk = ~clk;

    int          errors = 0;
    int          checks = 0;
    int          expq[$];
    byte unsigned body_q[$];
    bit          pad_m = 1'b1;
    bit          crc_m = 1'b1;
    bit          stall_on = 1'b0;
    bit          done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] last4 = '0;
    string       cur_req = "R5";

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // downstream ready pattern
    always @(posedge clk) begin
        #2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        m_ready = !stall_on || (lfsr[1:0] != 2'b00);
    end

    // compare every accepted output byte against the model queue
    always @(negedge clk) begin
        if (!rst && m_valid && m_ready) begin
            last4 = {m_data, last4[31:8]};
            if (expq.size() == 0) begin
                check(1'b0, cur_req, "unexpected beat", {m_sof, m_eof, m_data}, 0);
            end else begin
                int e;
                e = expq.pop_front();
                check({m_sof, m_eof, m_data} == e[9:0], cur_req, "stream beat",
                      {m_sof, m_eof, m_data}, e[9:0]);
            end
        end
    end

    // behavioural model: builds expected output from body_q and mode shadow
    task automatic expect_frame();
        byte unsigned fr[$];
        logic [31:0]  c;
        int           n;
        fr = body_q;
        if (pad_m && crc_m) while (fr.size() < MIN_BODY) fr.push_back(8'h00);
        if (crc_m) begin
            c = 32'hFFFFFFFF;
            foreach (fr[i]) begin
                for (int k = 0; k < 8; k++) begin
                    bit fb;
                    fb = c[0] ^ fr[i][k];
                    c  = c >> 1;
                    if (fb) c = c ^ 32'hEDB88320;
                end
            end
            c = ~c;
            for (int k = 0; k < 4; k++) fr.push_back(c[8*k +: 8]);
        end
        n = fr.size();
        foreach (fr[i]) expq.push_back({22'd0, (i == 0), (i == n - 1), fr[i]});
    endtask

    task automatic send_body(input int chg_at, input bit chg_sel, input logic [31:0] chg_val);
        int len;
        len = body_q.size();
        expect_frame();
        for (int i = 0; i < len; i++) begin
            bit acc;
            s_valid = 1'b1;
            s_data  = body_q[i];
            s_sof   = (i == 0);
            s_eof   = (i == len - 1);
            if (i == chg_at) begin
                cfg_we    = 1'b1;
                cfg_sel   = chg_sel;
                cfg_wdata = chg_val;
            end
            do begin
                @(negedge clk);
                acc = s_ready;
                @(posedge clk);
                #2;
            end while (!acc);
            cfg_we = 1'b0;
        end
        s_valid = 1'b0;
        s_sof   = 1'b0;
        s_eof   = 1'b0;
        if (chg_at >= 0) begin
            if (chg_sel) crc_m = chg_val[1];
            else         pad_m = chg_val[0];
        end
    endtask

    task automatic send_frame(input int len, input int seed);
        body_q.delete();
        for (int i = 0; i < len; i++) body_q.push_back(8'((seed + i * 7) & 8'hFF));
        send_body(-1, 1'b0, '0);
    endtask

    task automatic drain(input string req);
        int n = 0;
        while (expq.size() != 0 && n < 3000) begin
            @(posedge clk);
            #2;
            n++;
        end
        check(expq.size() == 0, req, "frame fully emitted, beats left", expq.size(), 0);
    endtask

    task automatic cfg_write(input bit sel, input logic [31:0] val);
        cfg_sel   = sel;
        cfg_wdata = val;
        cfg_we    = 1'b1;
        @(posedge clk);
        #2;
        cfg_we = 1'b0;
        if (sel) crc_m = val[1];
        else     pad_m = val[0];
    endtask

    task automatic cfg_read(input bit sel, input logic [31:0] exp, input string req);
        cfg_sel = sel;
        @(negedge clk);
        check(cfg_rdata == exp, req, "register read", cfg_rdata, exp);
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #2;
        rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        check(m_valid == 1'b0, "R1", "m_valid after reset", m_valid, 0);
        check(cfg_err == 1'b0, "R1", "cfg_err after reset", cfg_err, 0);
        @(posedge clk);
        #2;
        cfg_read(1'b0, 32'h1, "R1");
        cfg_read(1'b1, 32'h3, "R1");

        // R2 pad word
        cfg_write(1'b0, 32'hFFFF_FFFE);
        cfg_read(1'b0, 32'h0, "R2");
        cfg_write(1'b0, 32'hFFFF_FFFF);
        cfg_read(1'b0, 32'h1, "R2");

        // R3 CRC word, R4 error flag
        cfg_write(1'b1, 32'h0);
        cfg_read(1'b1, 32'h1, "R3");
        @(negedge clk);
        check(cfg_err == 1'b1, "R4", "cfg_err pad on crc off", cfg_err, 1);
        @(posedge clk);
        #2;
        cfg_write(1'b1, 32'hFFFF_FFFF);
        cfg_read(1'b1, 32'h3, "R3");
        @(negedge clk);
        check(cfg_err == 1'b0, "R4", "cfg_err both on", cfg_err, 0);
        @(posedge clk);
        #2;

        // R8 known vector, no padding
        cfg_write(1'b0, 32'h0);
        cur_req = "R8";
        body_q.delete();
        for (int i = 0; i < 9; i++) body_q.push_back(8'h31 + 8'(i));
        send_body(-1, 1'b0, '0);
        drain("R8");
        check(last4 == 32'hCBF43926, "R8", "check value of 123456789", last4, 32'hCBF43926);

        // R5 R6 R12 R13 short padded frames with stalls
        cfg_write(1'b0, 32'h1);
        stall_on = 1'b1;
        cur_req  = "R6 R12 R13";
        send_frame(10, 3);
        send_frame(1, 90);
        send_frame(59, 17);
        drain("R6");

        // R7 boundary and long frames
        cur_req = "R7 R5";
        send_frame(60, 5);
        send_frame(61, 44);
        send_frame(100, 201);
        drain("R7");

        // R9 no CRC, no pad
        stall_on = 1'b0;
        cfg_write(1'b0, 32'h0);
        cfg_write(1'b1, 32'h0);
        cur_req = "R9";
        send_frame(20, 11);
        send_frame(1, 7);
        drain("R9");

        // R10 pad on, crc off: misconfigured, no padding
        cfg_write(1'b0, 32'h1);
        @(negedge clk);
        check(cfg_err == 1'b1, "R10", "cfg_err flagged", cfg_err, 1);
        @(posedge clk);
        #2;
        cur_req = "R10";
        send_frame(5, 60);
        send_frame(1, 61);
        drain("R10");

        // R11 mid-frame mode changes apply at the next frame
        cfg_write(1'b1, 32'h2);
        stall_on = 1'b1;
        cur_req  = "R11";
        body_q.delete();
        for (int i = 0; i < 8; i++) body_q.push_back(8'(i + 100));
        send_body(3, 1'b1, 32'h0);
        send_frame(8, 33);
        body_q.delete();
        for (int i = 0; i < 12; i++) body_q.push_back(8'(i * 3));
        send_body(5, 1'b1, 32'h2);
        body_q.delete();
        for (int i = 0; i < 6; i++) body_q.push_back(8'(i + 9));
        send_body(2, 1'b0, 32'h0);
        send_frame(6, 77);
        drain("R11");
        stall_on = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL %s watchdog: actual hung expected finished", cur_req);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule